// File: doc/BRIEF.md
# Quad-Lane SPI Write Master

This block is a serial master that pushes bytes to a quad-I/O flash device over four data lines at once. Each byte leaves as two 4-bit beats, high beat first, so one byte takes two SCK cycles. Software writes bytes into a single holding register. The block drains that register whenever a frame begins. The chip select stays low as long as software keeps the register filled before each frame ends.

Quad writing is possible only when quad mode is on and the read-direction select is clear. Quad mode can be switched on only while the holding register is empty and no transfer is running. The SCK half period, the idle level of SCK and the sampling phase are all set by configuration inputs. When the read direction is selected, the block lets go of all four lines and starts nothing.

Top module: `qspiw_master`

## Requirements
- R1: With quad mode on and `cfg_read_sel` low, `io_oe` reads 4'hF. It follows the mode state after one register stage.
- R2: A rising `cfg_quad_req` switches quad mode on only when `tx_empty` is high and no transfer is running. At any other moment the request is ignored: `io_oe` stays 0 and nothing is sent.
- R3: With `cfg_enable` high, quad write selected and a byte held, `nss` falls. The first SCK edge comes two half periods later, where one half period is `cfg_presc`+1 clock cycles.
- R4: Each byte takes two SCK cycles. The high nibble goes first, and bit n of the nibble appears on `io_out[n]`. With `cfg_cpha`=0, data is stable at each leading edge. With `cfg_cpha`=1, data is driven at the leading edge and stable at the trailing edge. SCK rests at `cfg_cpol`.
- R5: A `wr_valid` pulse loads `wr_data` only while `tx_empty` is high, and `tx_empty` then falls. A write while the register is full is dropped. `tx_empty` rises again in the same cycle that the byte is taken for shifting.
- R6: At the last edge of a frame, a waiting byte starts the next frame at once. SCK edges continue at the same pace and `nss` stays low. Without a waiting byte, SCK stops at its idle level.
- R7: `nss` returns high exactly two half periods after the final SCK edge.
- R8: `busy` rises with the first SCK edge of a transfer and falls when `nss` returns high. It is never high while `nss` is high.
- R9: While `cfg_read_sel` is high, `io_oe` is 0 and no transfer starts. A held byte stays in the register and is sent after the select clears.
- R10: After reset, `nss`=1, `busy`=0, `tx_empty`=1, `io_oe`=0 and `sck`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Block enable |
| cfg_quad_req | input | 1 | Request for quad mode |
| cfg_read_sel | input | 1 | Read-direction select (1 = lines released, no write) |
| cfg_presc | input | PRESC_W | Half-period length minus one, in clock cycles |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Sampling phase (0 = leading edge, 1 = trailing edge) |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to send |
| sck | output | 1 | Serial clock |
| nss | output | 1 | Chip select, active low |
| io_out | output | LANES | Data lines, bit n on line n |
| io_oe | output | LANES | Per-line output enables |
| busy | output | 1 | Transfer in progress |
| tx_empty | output | 1 | Holding register empty |

## Verification
The hardest state to reach is a frame boundary that has a byte waiting. A write must land after the previous byte was taken but before the last edge of the current frame. The stimulus reaches it by polling `tx_empty` on the falling clock edge and writing at once, which at the smallest prescaler still leaves several cycles of margin. The test then checks that `nss` rose exactly once across a three-byte stream. A dropped write into a full register is forced the same way: one byte is written straight after another, with a slow prescaler, while the first byte is already shifting.

// File: rtl/qspiw_pkg.sv
package qspiw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } qspiw_state_e;
endpackage

// File: rtl/qspiw_clkdiv.sv
module qspiw_clkdiv #(
  parameter int PRESC_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);
  logic [PRESC_W-1:0] cnt;

  // one tick per half period while a transfer runs
  assign tick = run && (cnt == presc);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (run && $stable(presc)) |-> (cnt <= presc));
endmodule

// File: rtl/qspiw_txbuf.sv
module qspiw_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              empty,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      empty <= 1'b1;
      data  <= '0;
    end else if (take) begin
      empty <= 1'b1;
    end else if (wr_valid && empty) begin
      data  <= wr_data;
      empty <= 1'b0;
    end
  end

  p_take_full_r5: assert property (@(posedge clk) disable iff (rst)
    take |-> !empty);
  p_full_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (!empty && !take) |=> $stable(data));
endmodule

// File: rtl/qspiw_ctrl.sv
module qspiw_ctrl
  import qspiw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              go_ok,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              buf_empty,
  input  logic [DATA_W-1:0] buf_data,
  output logic              take,
  output logic              running,
  output logic              idle,
  output logic              sck,
  output logic              nss,
  output logic [LANES-1:0]  io_out,
  output logic              busy
);
  localparam int BEATS = DATA_W / LANES;
  localparam int EDGES = 2 * BEATS;
  localparam int EW    = (EDGES > 2) ? $clog2(EDGES) : 1;
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  qspiw_state_e      state;
  logic [DATA_W-1:0] shreg;
  logic [EW-1:0]     edge_idx;
  logic              start;
  logic              frame_end;
  logic              drive_now;

  always_comb begin
    start     = (state == ST_IDLE) && go_ok && !buf_empty;
    frame_end = (state == ST_SHIFT) && tick && (edge_idx == LAST_EDGE);
    take      = start || (frame_end && !buf_empty);
    running   = (state != ST_IDLE);
    idle      = (state == ST_IDLE);
    // phase 0 changes data on trailing edges, phase 1 on leading edges
    if (cpha) drive_now = !edge_idx[0];
    else      drive_now = edge_idx[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sck      <= 1'b0;
      nss      <= 1'b1;
      busy     <= 1'b0;
      io_out   <= '0;
      shreg    <= '0;
      edge_idx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          sck      <= cpol;
          edge_idx <= '0;
          if (start) begin
            nss   <= 1'b0;
            state <= ST_LEAD;
            if (cpha) begin
              shreg <= buf_data;
            end else begin
              io_out <= buf_data[DATA_W-1 -: LANES];
              shreg  <= buf_data << LANES;
            end
          end
        end
        ST_LEAD: begin
          if (tick) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (tick) begin
            sck  <= ~sck;
            busy <= 1'b1;
            if (edge_idx == LAST_EDGE) begin
              edge_idx <= '0;
              if (!buf_empty) begin
                if (cpha) begin
                  shreg <= buf_data;
                end else begin
                  io_out <= buf_data[DATA_W-1 -: LANES];
                  shreg  <= buf_data << LANES;
                end
              end else begin
                state <= ST_TAIL;
              end
            end else begin
              edge_idx <= edge_idx + 1'b1;
              if (drive_now) begin
                io_out <= shreg[DATA_W-1 -: LANES];
                shreg  <= shreg << LANES;
              end
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            if (edge_idx[0]) begin
              state    <= ST_IDLE;
              nss      <= 1'b1;
              busy     <= 1'b0;
              edge_idx <= '0;
            end else begin
              edge_idx <= EW'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_busy_nss_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !nss);
  p_sck_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sck) && !nss && $past(!nss)) |-> busy);
  p_start_gate_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(nss) |-> $past(go_ok));
  p_rest_level_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && !nss && $past(!nss)) |-> $stable(sck));
endmodule

// File: rtl/qspiw_master.sv
module qspiw_master #(
  parameter int DATA_W  = 8,
  parameter int LANES   = 4,
  parameter int PRESC_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_enable,
  input  logic               cfg_quad_req,
  input  logic               cfg_read_sel,
  input  logic [PRESC_W-1:0] cfg_presc,
  input  logic               cfg_cpol,
  input  logic               cfg_cpha,
  input  logic               wr_valid,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               sck,
  output logic               nss,
  output logic [LANES-1:0]   io_out,
  output logic [LANES-1:0]   io_oe,
  output logic               busy,
  output logic               tx_empty
);
  logic              quad_q;
  logic              go_ok;
  logic              tick;
  logic              take;
  logic              running;
  logic              idle;
  logic [DATA_W-1:0] buf_data;
  logic [LANES-1:0]  oe_q;

  assign go_ok = cfg_enable && quad_q && !cfg_read_sel;

  // quad mode may only be entered with an empty register and no transfer
  always_ff @(posedge clk) begin
    if (rst) begin
      quad_q <= 1'b0;
    end else if (cfg_quad_req && !quad_q && tx_empty && idle) begin
      quad_q <= 1'b1;
    end else if (!cfg_quad_req && idle) begin
      quad_q <= 1'b0;
    end
  end

  // every line becomes an output in quad write
  for (genvar g = 0; g < LANES; g++) begin : g_lane_oe
    always_ff @(posedge clk) begin
      if (rst) oe_q[g] <= 1'b0;
      else     oe_q[g] <= quad_q && !cfg_read_sel;
    end
  end
  assign io_oe = oe_q;

  qspiw_clkdiv #(.PRESC_W(PRESC_W)) i_div (
    .clk   (clk),
    .rst   (rst),
    .run   (running),
    .presc (cfg_presc),
    .tick  (tick)
  );

  qspiw_txbuf #(.DATA_W(DATA_W)) i_buf (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .take     (take),
    .empty    (tx_empty),
    .data     (buf_data)
  );

  qspiw_ctrl #(.DATA_W(DATA_W), .LANES(LANES)) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .go_ok     (go_ok),
    .cpol      (cfg_cpol),
    .cpha      (cfg_cpha),
    .buf_empty (tx_empty),
    .buf_data  (buf_data),
    .take      (take),
    .running   (running),
    .idle      (idle),
    .sck       (sck),
    .nss       (nss),
    .io_out    (io_out),
    .busy      (busy)
  );

  p_oe_read_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_read_sel |=> (io_oe == '0));
  p_quad_entry_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(quad_q) |-> ($past(tx_empty) && $past(idle)));
  p_oe_mode_r1: assert property (@(posedge clk) disable iff (rst)
    (io_oe != '0) |-> $past(quad_q));
endmodule

// File: tb/test_qspiw_master.sv
module test_qspiw_master;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_enable = 1'b0;
  logic       cfg_quad_req = 1'b0;
  logic       cfg_read_sel = 1'b0;
  logic [3:0] cfg_presc = 4'd0;
  logic       cfg_cpol = 1'b0;
  logic       cfg_cpha = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sck, nss, busy, tx_empty;
  logic [3:0] io_out, io_oe;

  qspiw_master i_qspiw_master (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_quad_req(cfg_quad_req),
    .cfg_read_sel(cfg_read_sel), .cfg_presc(cfg_presc), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .wr_valid(wr_valid), .wr_data(wr_data), .sck(sck),
    .nss(nss), .io_out(io_out), .io_oe(io_oe), .busy(busy), .tx_empty(tx_empty)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // receiver model: samples the lines on the edge chosen by the phase
  logic [7:0] rx_bytes [0:63];
  int  rx_n = 0;
  int  edges = 0, falls = 0, rises = 0;
  int  fall_cyc = 0, first_cyc = 0, last_cyc = 0, rise_cyc = 0;
  bit  first_pend = 0, busy_first = 0, busy_early = 0, busy_rise = 0;
  bit  nib_half = 0;
  logic [3:0] nib_hi = 4'h0;
  logic sck_p = 1'b0, nss_p = 1'b1;

  always @(negedge clk) begin
    if (nss_p && !nss) begin
      falls++;
      fall_cyc = cyc;
      first_pend = 1;
      nib_half = 0;
    end
    if (!nss) begin
      if (sck != sck_p) begin
        edges++;
        last_cyc = cyc;
        if (first_pend) begin
          first_cyc = cyc;
          busy_first = busy;
          first_pend = 0;
        end
        if ((sck != cfg_cpol) != cfg_cpha) begin
          if (!nib_half) begin
            nib_hi = io_out;
            nib_half = 1;
          end else begin
            if (rx_n < 64) rx_bytes[rx_n] = {nib_hi, io_out};
            rx_n++;
            nib_half = 0;
          end
        end
      end else if (first_pend && busy) begin
        busy_early = 1;
      end
    end
    if (!nss_p && nss) begin
      rises++;
      rise_cyc = cyc;
      busy_rise = busy;
    end
    sck_p = sck;
    nss_p = nss;
  end

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_rises(input int target);
    while (rises < target) @(negedge clk);
  endtask

  // fields: [31:28] prescaler, [27] idle level, [26] phase, [25:24] byte count, then three bytes
  localparam logic [31:0] VEC [0:5] = '{
    32'h01A50000,
    32'h1A3CF000,
    32'h27123456,
    32'h0F817EC3,
    32'h330FE199,
    32'h06FF0000
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R3 watchdog: actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(nss == 1'b1, "R10 nss", nss, 1);
    chk(busy == 1'b0, "R10 busy", busy, 0);
    chk(tx_empty == 1'b1, "R10 tx_empty", tx_empty, 1);
    chk(io_oe == 4'h0, "R10 io_oe", io_oe, 0);
    chk(sck == 1'b0, "R10 sck", sck, 0);

    // R1: quad mode on, write direction
    cfg_enable   = 1'b1;
    cfg_quad_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(io_oe == 4'hF, "R1 io_oe", io_oe, 4'hF);

    for (int v = 0; v < 6; v++) begin
      int nb, r0, e0, f0, h;
      cfg_presc = VEC[v][31:28];
      cfg_cpol  = VEC[v][27];
      cfg_cpha  = VEC[v][26];
      nb = int'(VEC[v][25:24]);
      h  = int'(VEC[v][31:28]) + 1;
      repeat (2) @(negedge clk);
      r0 = rx_n; e0 = edges; f0 = rises;
      busy_early = 0;
      for (int i = 0; i < nb; i++) write_byte(VEC[v][23 - 8*i -: 8]);
      wait_rises(f0 + 1);
      repeat (4 * h + 4) @(negedge clk);
      chk(rises == f0 + 1, "R6 single nss pulse", rises - f0, 1);
      chk(rx_n - r0 == nb, "R4 byte count", rx_n - r0, nb);
      for (int i = 0; i < nb; i++)
        chk(rx_bytes[r0 + i] == VEC[v][23 - 8*i -: 8], "R4 data",
            rx_bytes[r0 + i], VEC[v][23 - 8*i -: 8]);
      chk(edges - e0 == 4 * nb, "R6 edge count", edges - e0, 4 * nb);
      chk(first_cyc - fall_cyc == 2 * h, "R3 lead gap", first_cyc - fall_cyc, 2 * h);
      chk(rise_cyc - last_cyc == 2 * h, "R7 tail gap", rise_cyc - last_cyc, 2 * h);
      chk(busy_first && !busy_early, "R8 busy at first edge", busy_first, 1);
      chk(!busy_rise, "R8 busy at nss rise", busy_rise, 0);
      chk(sck == cfg_cpol, "R4 sck idle", sck, cfg_cpol);
      chk(io_oe == 4'hF, "R1 io_oe kept", io_oe, 4'hF);
    end

    // R9: read direction releases lines and holds the byte
    begin
      int f0, r0;
      cfg_read_sel = 1'b1;
      repeat (2) @(negedge clk);
      chk(io_oe == 4'h0, "R9 io_oe", io_oe, 0);
      f0 = falls; r0 = rx_n;
      write_byte(8'h6D);
      repeat (40) @(negedge clk);
      chk(falls == f0, "R9 no start", falls - f0, 0);
      chk(tx_empty == 1'b0, "R9 byte held", tx_empty, 0);
      cfg_read_sel = 1'b0;
      wait_rises(rises + 1);
      chk(rx_n - r0 == 1 && rx_bytes[r0] == 8'h6D, "R9 sent after clear",
          rx_bytes[r0], 8'h6D);
    end

    // R5: write into a full register is dropped
    begin
      int r0, e0, f0;
      cfg_presc = 4'd3; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
      repeat (2) @(negedge clk);
      r0 = rx_n; e0 = edges; f0 = rises;
      write_byte(8'h11);
      write_byte(8'h22);
      wr_valid = 1'b1; wr_data = 8'h33;
      @(negedge clk);
      wr_valid = 1'b0;
      wait_rises(f0 + 1);
      repeat (20) @(negedge clk);
      chk(rx_n - r0 == 2, "R5 count", rx_n - r0, 2);
      chk(rx_bytes[r0] == 8'h11, "R5 first", rx_bytes[r0], 8'h11);
      chk(rx_bytes[r0 + 1] == 8'h22, "R5 second", rx_bytes[r0 + 1], 8'h22);
      chk(edges - e0 == 8, "R5 edges", edges - e0, 8);
      chk(tx_empty == 1'b1, "R5 empty after", tx_empty, 1);
    end

    // R2: quad request with a held byte is ignored
    begin
      int f0;
      rst = 1'b1; cfg_quad_req = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      f0 = falls;
      write_byte(8'h5A);
      cfg_quad_req = 1'b1;
      repeat (20) @(negedge clk);
      chk(io_oe == 4'h0, "R2 io_oe", io_oe, 0);
      chk(falls == f0, "R2 no transfer", falls - f0, 0);
      chk(tx_empty == 1'b0, "R2 byte held", tx_empty, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule